// File: doc/BRIEF.md
# Event Trigger Prescaler

This block turns the event strobes of a PWM time base into conversion-start pulses for two independent channels, A and B. The time base supplies a zero-match strobe, a period-match strobe, compare-A and compare-B match strobes and a direction flag. Each channel picks one of these, qualified by direction where that matters, through a 3-bit source code. It then counts occurrences in a 2-bit counter.

When a selected event brings the count to the channel's 2-bit period and the channel is enabled, the channel emits a registered start pulse one clock wide and its counter returns to zero. A period of N therefore gives one pulse for every N selected events. Software can preload each counter with an initial value through a load strobe, which sets the phase of the decimation. Both counters are visible at the outputs. Every clock edge is one time-base tick.

Top module: `evtrig_prescaler`

## Requirements
- R1: After synchronous active-low reset both start pulses are 0 and both counters read 0.
- R2: Source codes select events as follows: 001 zero, 010 period, 011 zero or period, 100 compare A with count_up=1, 101 compare A with count_up=0, 110 compare B with count_up=1, 111 compare B with count_up=0.
- R3: Source code 000 selects no event, so the counter never advances and no pulse is produced.
- R4: On each selected event that does not reach the period, the counter increases by one. Without a selected event or a load, it holds its value.
- R5: With the channel enabled and a non-zero period, the selected event that brings the count to the period makes the start pulse high for exactly the next clock, and the counter reads 0 in that same clock.
- R6: A period of 0 freezes the counter and suppresses all pulses.
- R7: With the channel disabled, the counter climbs to the period and holds there, with no pulse.
- R8: The load strobe copies the initial value into the counter at the next clock edge, taking priority over a simultaneous event, and produces no pulse.
- R9: The two channels share only the event inputs; the configuration and counter of one channel never affect the other.
- R10: If the counter already stands at or above the period when the channel is enabled, the next selected event fires a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_zero | input | 1 | Time-base counter equals zero |
| evt_period | input | 1 | Time-base counter equals period |
| evt_cmpa | input | 1 | Time-base counter equals compare A |
| evt_cmpb | input | 1 | Time-base counter equals compare B |
| count_up | input | 1 | 1 while the time base counts up, 0 while it counts down |
| a_enable | input | 1 | Channel A pulse enable |
| a_source | input | 3 | Channel A event source code |
| a_period | input | 2 | Channel A events per pulse (0 = off) |
| a_init | input | 2 | Channel A counter preload value |
| a_init_load | input | 1 | Channel A preload strobe |
| b_enable | input | 1 | Channel B pulse enable |
| b_source | input | 3 | Channel B event source code |
| b_period | input | 2 | Channel B events per pulse (0 = off) |
| b_init | input | 2 | Channel B counter preload value |
| b_init_load | input | 1 | Channel B preload strobe |
| soc_a | output | 1 | Channel A start pulse |
| soc_b | output | 1 | Channel B start pulse |
| a_count | output | 2 | Channel A event counter |
| b_count | output | 2 | Channel B event counter |

## Verification
The embedded assertions check on every cycle that source 000 never produces an event, that a counter holds when neither an event nor a load arrives, that a load lands its initial value, and that every pulse follows an enabled event at a non-zero period and leaves the counter at zero. Which event each source code decodes to, the every-N-th decimation, saturation while disabled, the preload phase and channel independence are shown only by the bench's directed scenarios, which compare the ports against values worked out from the requirements.

// File: rtl/evtrig_pkg.sv
// Package: shared widths and source-select encoding for the event trigger prescaler.
// Assumes: every user of the source code treats unlisted values as no source.
package evtrig_pkg;
    localparam int CNT_W = 2;
    localparam int SEL_W = 3;
    localparam int NUM_CH = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_NONE     = 3'd0,
        SRC_ZERO     = 3'd1,
        SRC_PRD      = 3'd2,
        SRC_ZERO_PRD = 3'd3,
        SRC_CA_UP    = 3'd4,
        SRC_CA_DN    = 3'd5,
        SRC_CB_UP    = 3'd6,
        SRC_CB_DN    = 3'd7
    } src_sel_e;

    typedef struct packed {
        logic zero;
        logic prd;
        logic cmpa;
        logic cmpb;
        logic up;
    } tb_events_t;
endpackage

// File: rtl/evtrig_source_mux.sv
// Module: evtrig_source_mux
// Picks one direction-qualified time-base event for a channel.
// Assumes: event strobes are one tick wide and up is valid whenever a strobe is.
module evtrig_source_mux
    import evtrig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  tb_events_t       events,
    input  logic [SEL_W-1:0] sel,
    output logic             evt_out
);
    src_sel_e sel_e;

    // Decode the source code into the selected event strobe.
    always_comb begin
        sel_e = src_sel_e'(sel);
        unique case (sel_e)
            SRC_NONE:     evt_out = 1'b0;
            SRC_ZERO:     evt_out = events.zero;
            SRC_PRD:      evt_out = events.prd;
            SRC_ZERO_PRD: evt_out = events.zero | events.prd;
            SRC_CA_UP:    evt_out = events.cmpa & events.up;
            SRC_CA_DN:    evt_out = events.cmpa & ~events.up;
            SRC_CB_UP:    evt_out = events.cmpb & events.up;
            SRC_CB_DN:    evt_out = events.cmpb & ~events.up;
            default:      evt_out = 1'b0;
        endcase
    end

    // Code 000 must never yield an event.
    assert_sel_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> !evt_out);
endmodule

// File: rtl/evtrig_decimator.sv
// Module: evtrig_decimator
// Counts selected events and emits a registered one-tick pulse on every N-th.
// Assumes: period 0 means off; load has priority over an event in the same tick.
module evtrig_decimator
    import evtrig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             enable,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] init_val,
    input  logic             init_load,
    output logic             pulse,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pulse_q;
    logic             reach;
    logic             active;
    logic             fire;

    // Decide whether this event reaches the period and what the counter becomes.
    always_comb begin
        reach  = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period};
        active = evt && (period != '0) && !init_load;
        fire   = active && enable && reach;
        cnt_d  = cnt_q;
        if (init_load)
            cnt_d = init_val;
        else if (active) begin
            if (!reach)
                cnt_d = cnt_q + 1'b1;
            else if (enable)
                cnt_d = '0;
            else
                cnt_d = period;
        end
    end

    // Register the counter and the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            pulse_q <= fire;
        end
    end

    assign pulse = pulse_q;
    assign count = cnt_q;

    // A pulse leaves the counter at zero.
    assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (cnt_q == '0));
    // A pulse needs an enabled event at non-zero period one tick earlier.
    assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> ($past(evt) && $past(enable) && ($past(period) != '0)));
    // Without event or load the counter holds.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !init_load) |=> $stable(cnt_q));
    // A load lands its value and makes no pulse.
    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_load |=> ((cnt_q == $past(init_val)) && !pulse_q));
endmodule

// File: rtl/evtrig_prescaler.sv
// Module: evtrig_prescaler (top)
// Two independent event-trigger channels, each a source mux feeding a decimator.
// Assumes: one clock edge per time-base tick; configuration is quasi-static.
module evtrig_prescaler
    import evtrig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_zero,
    input  logic       evt_period,
    input  logic       evt_cmpa,
    input  logic       evt_cmpb,
    input  logic       count_up,
    input  logic       a_enable,
    input  logic [2:0] a_source,
    input  logic [1:0] a_period,
    input  logic [1:0] a_init,
    input  logic       a_init_load,
    input  logic       b_enable,
    input  logic [2:0] b_source,
    input  logic [1:0] b_period,
    input  logic [1:0] b_init,
    input  logic       b_init_load,
    output logic       soc_a,
    output logic       soc_b,
    output logic [1:0] a_count,
    output logic [1:0] b_count
);
    tb_events_t       events;
    logic             en_v   [NUM_CH];
    logic [SEL_W-1:0] sel_v  [NUM_CH];
    logic [CNT_W-1:0] prd_v  [NUM_CH];
    logic [CNT_W-1:0] init_v [NUM_CH];
    logic             load_v [NUM_CH];
    logic             evt_v  [NUM_CH];
    logic             soc_v  [NUM_CH];
    logic [CNT_W-1:0] cnt_v  [NUM_CH];

    // Bundle the shared time-base strobes.
    always_comb begin
        events.zero = evt_zero;
        events.prd  = evt_period;
        events.cmpa = evt_cmpa;
        events.cmpb = evt_cmpb;
        events.up   = count_up;
    end

    // Gather per-channel configuration into indexed form.
    always_comb begin
        en_v[0]   = a_enable;    en_v[1]   = b_enable;
        sel_v[0]  = a_source;    sel_v[1]  = b_source;
        prd_v[0]  = a_period;    prd_v[1]  = b_period;
        init_v[0] = a_init;      init_v[1] = b_init;
        load_v[0] = a_init_load; load_v[1] = b_init_load;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        evtrig_source_mux u_mux (
            .clk     (clk),
            .rst_n   (rst_n),
            .events  (events),
            .sel     (sel_v[ch]),
            .evt_out (evt_v[ch])
        );
        evtrig_decimator u_dec (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (evt_v[ch]),
            .enable    (en_v[ch]),
            .period    (prd_v[ch]),
            .init_val  (init_v[ch]),
            .init_load (load_v[ch]),
            .pulse     (soc_v[ch]),
            .count     (cnt_v[ch])
        );
    end

    assign soc_a   = soc_v[0];
    assign soc_b   = soc_v[1];
    assign a_count = cnt_v[0];
    assign b_count = cnt_v[1];
endmodule

// File: tb/evtrig_prescaler_bench.sv
module evtrig_prescaler_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_zero = 0, evt_period = 0, evt_cmpa = 0, evt_cmpb = 0, count_up = 1;
    logic a_enable = 0, b_enable = 0;
    logic [2:0] a_source = 0, b_source = 0;
    logic [1:0] a_period = 0, b_period = 0, a_init = 0, b_init = 0;
    logic a_init_load = 0, b_init_load = 0;
    logic soc_a, soc_b;
    logic [1:0] a_count, b_count;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    evtrig_prescaler u_evtrig_prescaler (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One tick with the given strobes; returns just after the edge.
    task automatic ev(input logic z, input logic p, input logic a, input logic b, input logic up);
        @(negedge clk);
        evt_zero = z; evt_period = p; evt_cmpa = a; evt_cmpb = b; count_up = up;
        @(posedge clk); #1;
        evt_zero = 0; evt_period = 0; evt_cmpa = 0; evt_cmpb = 0;
    endtask

    task automatic load_a(input logic [1:0] v);
        @(negedge clk); a_init = v; a_init_load = 1;
        @(posedge clk); #1; a_init_load = 0;
    endtask

    task automatic load_b(input logic [1:0] v);
        @(negedge clk); b_init = v; b_init_load = 1;
        @(posedge clk); #1; b_init_load = 0;
    endtask

    task automatic t_reset();
        chk("R1 soc_a", soc_a, 0);
        chk("R1 soc_b", soc_b, 0);
        chk("R1 a_count", a_count, 0);
        chk("R1 b_count", b_count, 0);
    endtask

    task automatic t_cmpa_up_every_second();
        a_source = 3'b100; a_period = 2; a_enable = 1; load_a(0);
        ev(0, 0, 1, 0, 1);
        chk("R4 count after first", a_count, 1);
        chk("R4 no pulse yet", soc_a, 0);
        ev(0, 0, 1, 0, 0);
        chk("R2 cmpa down ignored", a_count, 1);
        ev(0, 0, 1, 0, 1);
        chk("R5 pulse on second", soc_a, 1);
        chk("R5 counter cleared", a_count, 0);
        ev(0, 0, 0, 0, 1);
        chk("R5 pulse one tick", soc_a, 0);
    endtask

    task automatic t_sources();
        b_period = 1; b_enable = 1;
        for (int s = 1; s < 8; s++) begin
            logic [4:0] hit, miss;
            b_source = 3'(s); load_b(0);
            case (s)
                1: begin hit = 5'b10001; miss = 5'b01001; end
                2: begin hit = 5'b01001; miss = 5'b10001; end
                3: begin hit = 5'b01001; miss = 5'b00101; end
                4: begin hit = 5'b00101; miss = 5'b00100; end
                5: begin hit = 5'b00100; miss = 5'b00101; end
                6: begin hit = 5'b00011; miss = 5'b00010; end
                default: begin hit = 5'b00010; miss = 5'b00011; end
            endcase
            ev(hit[4], hit[3], hit[2], hit[1], hit[0]);
            chk($sformatf("R2 source %0d match", s), soc_b, 1);
            ev(miss[4], miss[3], miss[2], miss[1], miss[0]);
            chk($sformatf("R2 source %0d nonmatch", s), soc_b, 0);
        end
        b_source = 3; ev(1, 0, 0, 0, 1);
        chk("R2 zero-or-period on zero", soc_b, 1);
        b_source = 0; b_enable = 0;
    endtask

    task automatic t_sel_none();
        a_source = 0; a_period = 1; a_enable = 1; load_a(0);
        ev(1, 1, 1, 1, 1);
        ev(1, 1, 1, 1, 0);
        chk("R3 no pulse", soc_a, 0);
        chk("R3 counter held", a_count, 0);
    endtask

    task automatic t_period_zero();
        a_source = 3'b001; a_period = 0; a_enable = 1; load_a(2);
        ev(1, 0, 0, 0, 1);
        chk("R6 no pulse", soc_a, 0);
        ev(1, 0, 0, 0, 1);
        chk("R6 counter frozen", a_count, 2);
    endtask

    task automatic t_disabled();
        a_source = 3'b001; a_period = 3; a_enable = 0; load_a(0);
        ev(1, 0, 0, 0, 1); chk("R7 count 1", a_count, 1);
        ev(1, 0, 0, 0, 1); chk("R7 count 2", a_count, 2);
        ev(1, 0, 0, 0, 1); chk("R7 count 3", a_count, 3);
        chk("R7 no pulse", soc_a, 0);
        ev(1, 0, 0, 0, 1); chk("R7 holds at period", a_count, 3);
        a_enable = 1;
        ev(1, 0, 0, 0, 1);
        chk("R10 fires after enable", soc_a, 1);
        chk("R10 counter cleared", a_count, 0);
    endtask

    task automatic t_preload();
        a_source = 3'b001; a_period = 3; a_enable = 1;
        load_a(2);
        chk("R8 preload value", a_count, 2);
        chk("R8 no pulse on load", soc_a, 0);
        @(negedge clk); a_init = 1; a_init_load = 1; evt_zero = 1;
        @(posedge clk); #1; a_init_load = 0; evt_zero = 0;
        chk("R8 load beats event", a_count, 1);
        chk("R8 no pulse with load", soc_a, 0);
        load_a(2);
        ev(1, 0, 0, 0, 1);
        chk("R5 pulse from preloaded phase", soc_a, 1);
        a_period = 2; load_a(3);
        ev(1, 0, 0, 0, 1);
        chk("R10 init above period fires", soc_a, 1);
    endtask

    task automatic t_independent();
        a_source = 3'b001; a_period = 1; a_enable = 1; load_a(0);
        b_source = 3'b010; b_period = 2; b_enable = 1; load_b(1);
        ev(1, 0, 0, 0, 1);
        chk("R9 A fires", soc_a, 1);
        chk("R9 B silent", soc_b, 0);
        chk("R9 B count untouched", b_count, 1);
        ev(0, 1, 0, 0, 1);
        chk("R9 B fires", soc_b, 1);
        chk("R9 A silent", soc_a, 0);
        chk("R9 A count untouched", a_count, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        t_reset();
        t_cmpa_up_every_second();
        t_sources();
        t_sel_none();
        t_period_zero();
        t_disabled();
        t_preload();
        t_independent();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule